// File: doc/BRIEF.md
# Program Sequencer with Conditional Branch

This block owns the program counter of a DSP core that executes 24-bit instruction words. Each clock-enable pulse (`step`) it takes the instruction that was fetched at the current counter value and registers the next counter value. Most instructions simply advance the counter by one. Jump-class words select a branch action from a 9-bit condition code. That action can be a conditional jump on a flag of either accumulator, a test on the data-pointer low nibble, a test on the host handshake bit, a load from the serial-output register, or an absolute jump or call to the lower or upper half of program space. Return-class words pop the counter from a small return-address stack once their arithmetic/move part has run.

The branch target is formed from the already-incremented counter. Its top bit is kept, and a 2-bit bank and an 11-bit address taken from the instruction word are spliced in below it. Instruction memory, the ALU and the move datapath sit outside the block. They feed it the instruction word, the two flag sets, the nibble, the handshake bit and the serial-output register value.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-low reset sets `pc` to 0 and `sp` to 0.
- R2: While `step` is low, `pc` and `sp` keep their values whatever the other inputs do.
- R3: Class is `instr[23:22]`: 0 is ALU/move and 3 is load-immediate. Both set `pc` to `pc+1`, wrapping from 0x3FFF to 0, and leave `sp` unchanged.
- R4: Class 2 is jump, with condition code `instr[21:13]`. A code in 0x080..0x0AF with bit 0 clear is a flag test. Code bit 2 selects `flags_b` (1) or `flags_a` (0). Code bits 5:3 select the flag bit: 0 carry, 1 zero, 2 OV0, 3 OV1, 4 S0, 5 S1, which are also the bit positions in `flags_a`/`flags_b`. Code bit 1 is the flag value that makes the jump taken. When the test fails, `pc` becomes `pc+1`.
- R5: The jump target is {bit 13 of `pc+1`, `instr[1:0]`, `instr[12:2]`}.
- R6: Code 0x0B0 jumps when `dp_low`==0, 0x0B1 when `dp_low`!=0, 0x0B2 when `dp_low`==0xF, and 0x0B3 when `dp_low`!=0xF.
- R7: Code 0x0BC jumps when `rqm` is 0, and 0x0BE jumps when `rqm` is 1.
- R8: Code 0x000 loads `pc` from `so_val`.
- R9: Code 0x100 loads the target with bit 13 forced to 0, and 0x101 loads it with bit 13 forced to 1.
- R10: Codes 0x140 and 0x141 act like 0x100 and 0x101. They also push `pc+1` onto the return stack and increment `sp`.
- R11: Class 1 (return) loads `pc` from the most recently pushed entry and decrements `sp`.
- R12: Any other jump-class code sets `pc` to `pc+1` and leaves `sp` unchanged.
- R13: The return stack holds 4 entries and `sp` wraps modulo 4. A fifth nested call overwrites the oldest entry, and returns then read entries in wrapped pointer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Clock enable; one instruction is retired per cycle it is high |
| instr | input | 24 | Instruction word fetched at `pc` |
| flags_a | input | 6 | Accumulator A flags {S1,S0,OV1,OV0,Z,C} |
| flags_b | input | 6 | Accumulator B flags, same layout |
| dp_low | input | 4 | Low nibble of the data pointer |
| rqm | input | 1 | Host request-for-master status bit |
| so_val | input | 14 | Low bits of the serial-output register |
| pc | output | 14 | Program counter |
| sp | output | 2 | Return-stack pointer |

## Verification
The assertions assume that reset is held low at the first clock edge. They also assume that `instr`, the flag sets, `dp_low`, `rqm` and `so_val` are settled at every edge where `step` is high, since these are only sampled there. The stimulus holds reset from time zero and changes every input only on the falling clock edge. Each `step` pulse lasts exactly one cycle, and results are read at the following falling edge. Condition inputs are driven with the flag under test opposite to every other flag, so a wrong flag index or accumulator selection changes the outcome.

// File: rtl/pcseq_pkg.sv
// Shared widths, instruction classes and branch-action encoding for the
// program sequencer. Assumes a 24-bit instruction word.
package pcseq_pkg;
    localparam int unsigned INSTR_W = 24;
    localparam int unsigned NA_W    = 11;
    localparam int unsigned BANK_W  = 2;
    localparam int unsigned PC_W    = 1 + BANK_W + NA_W;
    localparam int unsigned CODE_W  = 9;
    localparam int unsigned FLAG_W  = 6;

    typedef enum logic [1:0] {
        CLS_OP  = 2'd0,
        CLS_RET = 2'd1,
        CLS_JMP = 2'd2,
        CLS_LDI = 2'd3
    } instr_class_e;

    typedef enum logic [2:0] {
        ACT_NEXT   = 3'd0,
        ACT_TARGET = 3'd1,
        ACT_SERIAL = 3'd2,
        ACT_LOW    = 3'd3,
        ACT_HIGH   = 3'd4
    } branch_act_e;

    typedef struct packed {
        branch_act_e act;
        logic        push;
    } branch_dec_t;
endpackage

// File: rtl/pcseq_branch_decode.sv
// Turns a 9-bit jump condition code plus the live status inputs into a
// branch action and a push request. Purely combinational; assumes the
// caller only uses the result for jump-class instructions.
module pcseq_branch_decode
    import pcseq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [FLAG_W-1:0] flags_a,
    input  logic [FLAG_W-1:0] flags_b,
    input  logic [3:0]        dp_low,
    input  logic              rqm,
    output branch_dec_t       dec
);
    localparam int unsigned PAD_W = 8;

    logic [PAD_W-1:0] flag_pad;
    logic [2:0]       flag_idx;
    logic             flag_code;

    // Select the accumulator flag set and the flag named by the code.
    always_comb begin
        flag_pad  = {{(PAD_W-FLAG_W){1'b0}}, (code[2] ? flags_b : flags_a)};
        flag_idx  = code[5:3];
        flag_code = (code[8:6] == 3'b010) && !code[0]
                    && (32'(flag_idx) < FLAG_W);
    end

    // Resolve the branch action from the code table.
    always_comb begin
        dec = '{act: ACT_NEXT, push: 1'b0};
        if (flag_code) begin
            if (flag_pad[flag_idx] == code[1]) dec.act = ACT_TARGET;
        end else begin
            case (code)
                9'h000: dec.act = ACT_SERIAL;
                9'h0B0: if (dp_low == 4'h0) dec.act = ACT_TARGET;
                9'h0B1: if (dp_low != 4'h0) dec.act = ACT_TARGET;
                9'h0B2: if (dp_low == 4'hF) dec.act = ACT_TARGET;
                9'h0B3: if (dp_low != 4'hF) dec.act = ACT_TARGET;
                9'h0BC: if (!rqm) dec.act = ACT_TARGET;
                9'h0BE: if (rqm)  dec.act = ACT_TARGET;
                9'h100: dec.act = ACT_LOW;
                9'h101: dec.act = ACT_HIGH;
                9'h140: dec = '{act: ACT_LOW,  push: 1'b1};
                9'h141: dec = '{act: ACT_HIGH, push: 1'b1};
                default: dec.act = ACT_NEXT;
            endcase
        end
    end
endmodule

// File: rtl/pcseq_ret_stack.sv
// Return-address stack with a wrapping pointer. Assumes DEPTH is a power
// of two and that push and pop are never requested together.
module pcseq_ret_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 14,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     top,
    output logic [PTR_W-1:0] ptr
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr_dec;

    // One write port per entry, enabled when the pointer addresses it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && ptr == PTR_W'(g)) mem[g] <= din;
        end
    end

    // Move the pointer up on push and down on pop, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (push) ptr <= ptr + PTR_W'(1);
        else if (pop)  ptr <= ptr_dec;
    end

    // Expose the most recently pushed entry.
    always_comb begin
        ptr_dec = ptr - PTR_W'(1);
        top     = mem[ptr_dec];
    end
endmodule

// File: rtl/pcseq_top.sv
// Program counter and branch unit. On each step pulse it retires the
// instruction at pc and registers the next pc. Assumes instr and the
// status inputs are valid during the step cycle.
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int unsigned STACK_DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step,
    input  logic [INSTR_W-1:0]             instr,
    input  logic [FLAG_W-1:0]              flags_a,
    input  logic [FLAG_W-1:0]              flags_b,
    input  logic [3:0]                     dp_low,
    input  logic                           rqm,
    input  logic [PC_W-1:0]                so_val,
    output logic [PC_W-1:0]                pc,
    output logic [$clog2(STACK_DEPTH)-1:0] sp
);
    instr_class_e  cls;
    branch_dec_t   dec;
    logic [PC_W-1:0] pc_inc, tgt, pc_nxt, stk_top;
    logic          do_push, do_pop;

    // Split the instruction word into class and target fields.
    always_comb begin
        cls    = instr_class_e'(instr[INSTR_W-1 -: 2]);
        pc_inc = pc + PC_W'(1);
        tgt    = {pc_inc[PC_W-1], instr[BANK_W-1:0], instr[BANK_W +: NA_W]};
    end

    pcseq_branch_decode i_dec (
        .code    (instr[INSTR_W-3 -: CODE_W]),
        .flags_a (flags_a),
        .flags_b (flags_b),
        .dp_low  (dp_low),
        .rqm     (rqm),
        .dec     (dec)
    );

    // Stack requests are qualified by step and the instruction class.
    always_comb begin
        do_push = step && (cls == CLS_JMP) && dec.push;
        do_pop  = step && (cls == CLS_RET);
    end

    pcseq_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) i_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .din   (pc_inc),
        .top   (stk_top),
        .ptr   (sp)
    );

    // Choose the next counter value from class and branch action.
    always_comb begin
        pc_nxt = pc_inc;
        case (cls)
            CLS_RET: pc_nxt = stk_top;
            CLS_JMP: begin
                case (dec.act)
                    ACT_TARGET: pc_nxt = tgt;
                    ACT_SERIAL: pc_nxt = so_val;
                    ACT_LOW:    pc_nxt = {1'b0, tgt[PC_W-2:0]};
                    ACT_HIGH:   pc_nxt = {1'b1, tgt[PC_W-2:0]};
                    default:    pc_nxt = pc_inc;
                endcase
            end
            default: pc_nxt = pc_inc;
        endcase
    end

    // Register the program counter on each step pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (step) pc <= pc_nxt;
    end
endmodule

// File: rtl/pcseq_checker.sv
// Temporal checks on the sequencer ports, bound to pcseq_top.
module pcseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        step,
    input logic [23:0] instr,
    input logic        carry_a,
    input logic [3:0]  dp_low,
    input logic [13:0] pc,
    input logic [1:0]  sp
);
    logic [1:0]  cls;
    logic [8:0]  code;
    logic [13:0] pc_plus, tgt;

    // Observer-side view of the instruction fields.
    always_comb begin
        cls     = instr[23:22];
        code    = instr[21:13];
        pc_plus = pc + 14'd1;
        tgt     = {pc_plus[13], instr[1:0], instr[12:2]};
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == 14'd0 && sp == 2'd0));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pc) && $stable(sp)));

    assert_sequential_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cls == 2'd0 || cls == 2'd3)) |=> (pc == $past(pc) + 14'd1 && sp == $past(sp)));

    assert_flag_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && code == 9'h080 && !carry_a) |=> (pc == $past(tgt)));

    assert_flag_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && code == 9'h080 && carry_a) |=> (pc == $past(pc) + 14'd1));

    assert_dp_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && code == 9'h0B0 && dp_low == 4'h0) |=> (pc == $past(tgt)));

    assert_low_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && code == 9'h100) |=> (pc == {1'b0, $past(tgt[12:0])}));

    assert_high_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && code == 9'h101) |=> (pc == {1'b1, $past(tgt[12:0])}));

    assert_call_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd2 && (code == 9'h140 || code == 9'h141)) |=> (sp == $past(sp) + 2'd1));

    assert_return_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cls == 2'd1) |=> (sp == $past(sp) - 2'd1));
endmodule

bind pcseq_top pcseq_checker i_pcseq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .instr   (instr),
    .carry_a (flags_a[0]),
    .dp_low  (dp_low),
    .pc      (pc),
    .sp      (sp)
);

// File: tb/test_pcseq_top.sv
`timescale 1ns/1ps
module test_pcseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [23:0] instr = 24'h0;
    logic [5:0]  flags_a = 6'h0;
    logic [5:0]  flags_b = 6'h0;
    logic [3:0]  dp_low = 4'h0;
    logic        rqm = 1'b0;
    logic [13:0] so_val = 14'h0;
    logic [13:0] pc;
    logic [1:0]  sp;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcseq_top i_pcseq_top (
        .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
        .flags_a(flags_a), .flags_b(flags_b), .dp_low(dp_low), .rqm(rqm),
        .so_val(so_val), .pc(pc), .sp(sp)
    );

    function automatic logic [23:0] mk_jmp(input logic [8:0] code, input logic [13:0] addr);
        return {2'b10, code, addr[10:0], addr[12:11]};
    endfunction

    task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic exec(input logic [23:0] ins);
        @(negedge clk);
        instr = ins;
        step  = 1'b1;
        @(negedge clk);
        step  = 1'b0;
    endtask

    task automatic set_pc(input logic [13:0] a);
        exec(mk_jmp(a[13] ? 9'h101 : 9'h100, a));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pc", pc, 14'h0);
        check("R1 sp", {12'h0, sp}, 14'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_hold;
        set_pc(14'h0123);
        @(negedge clk);
        instr = mk_jmp(9'h101, 14'h0555);
        so_val = 14'h1111;
        repeat (3) @(negedge clk);
        check("R2 pc held", pc, 14'h0123);
        check("R2 sp held", {12'h0, sp}, 14'h0);
    endtask

    task automatic t_sequential;
        set_pc(14'h0200);
        exec(24'h00ABCD);
        check("R3 class0", pc, 14'h0201);
        exec(24'hC12345);
        check("R3 class3", pc, 14'h0202);
        set_pc(14'h3FFF);
        exec(24'h000000);
        check("R3 wrap", pc, 14'h0000);
    endtask

    task automatic t_flags;
        for (int f = 0; f < 6; f++)
            for (int acc = 0; acc < 2; acc++)
                for (int pol = 0; pol < 2; pol++)
                    for (int v = 0; v < 2; v++) begin
                        logic [8:0] code;
                        logic [5:0] fv;
                        code = 9'h080 | 9'(f << 3) | 9'(acc << 2) | 9'(pol << 1);
                        fv = v ? 6'h00 : 6'h3F;
                        fv[f] = v[0];
                        set_pc(14'h0100);
                        @(negedge clk);
                        flags_a = acc ? (v ? 6'h00 : 6'h3F) ^ 6'h3F : fv;
                        flags_b = acc ? fv : (v ? 6'h00 : 6'h3F) ^ 6'h3F;
                        if (acc == 0) flags_b = ~fv;
                        else          flags_a = ~fv;
                        exec(mk_jmp(code, 14'h0555));
                        check("R4 flag branch", pc, (v == pol) ? 14'h0555 : 14'h0101);
                    end
        flags_a = 6'h00;
        flags_b = 6'h3F;
        set_pc(14'h2100);
        exec(mk_jmp(9'h080, 14'h0555));
        check("R5 target keeps bit13", pc, 14'h2555);
        set_pc(14'h0100);
        exec(mk_jmp(9'h080, 14'h1ABC));
        check("R5 target bank bits", pc, 14'h1ABC);
    endtask

    task automatic t_dp;
        logic [3:0] vals [3] = '{4'h0, 4'hF, 4'h7};
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 3; i++) begin
                logic tk;
                case (c)
                    0: tk = (vals[i] == 4'h0);
                    1: tk = (vals[i] != 4'h0);
                    2: tk = (vals[i] == 4'hF);
                    default: tk = (vals[i] != 4'hF);
                endcase
                set_pc(14'h0040);
                @(negedge clk);
                dp_low = vals[i];
                exec(mk_jmp(9'h0B0 + 9'(c), 14'h0777));
                check("R6 dp nibble", pc, tk ? 14'h0777 : 14'h0041);
            end
    endtask

    task automatic t_rqm;
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 2; r++) begin
                set_pc(14'h0060);
                @(negedge clk);
                rqm = r[0];
                exec(mk_jmp(c ? 9'h0BE : 9'h0BC, 14'h0333));
                check("R7 rqm", pc, (r == c) ? 14'h0333 : 14'h0061);
            end
    endtask

    task automatic t_serial;
        set_pc(14'h0010);
        @(negedge clk);
        so_val = 14'h2ACE;
        exec(mk_jmp(9'h000, 14'h0555));
        check("R8 serial load", pc, 14'h2ACE);
    endtask

    task automatic t_abs;
        set_pc(14'h2000);
        exec(mk_jmp(9'h100, 14'h1234));
        check("R9 low jump", pc, 14'h1234);
        exec(mk_jmp(9'h101, 14'h0234));
        check("R9 high jump", pc, 14'h2234);
    endtask

    task automatic t_call_ret;
        set_pc(14'h0010);
        exec(mk_jmp(9'h140, 14'h0200));
        check("R10 call pc", pc, 14'h0200);
        check("R10 call sp", {12'h0, sp}, 14'h1);
        exec(mk_jmp(9'h141, 14'h0300));
        check("R10 high call pc", pc, 14'h2300);
        check("R10 high call sp", {12'h0, sp}, 14'h2);
        exec(24'h400000);
        check("R11 return pc", pc, 14'h0201);
        check("R11 return sp", {12'h0, sp}, 14'h1);
        exec(24'h400000);
        check("R11 outer return pc", pc, 14'h0011);
        check("R11 outer return sp", {12'h0, sp}, 14'h0);
    endtask

    task automatic t_unlisted;
        logic [8:0] codes [6] = '{9'h001, 9'h081, 9'h0B4, 9'h0BD, 9'h102, 9'h1FF};
        flags_a = 6'h00;
        flags_b = 6'h00;
        for (int i = 0; i < 6; i++) begin
            set_pc(14'h0080);
            exec(mk_jmp(codes[i], 14'h0444));
            check("R12 unlisted pc", pc, 14'h0081);
            check("R12 unlisted sp", {12'h0, sp}, 14'h0);
        end
    endtask

    task automatic t_wrap;
        logic [13:0] exp_ret [5] = '{14'h0401, 14'h0301, 14'h0201, 14'h0101, 14'h0401};
        t_reset();
        set_pc(14'h0000);
        for (int i = 0; i < 5; i++) exec(mk_jmp(9'h140, 14'(14'h0100 * (i + 1))));
        check("R13 wrapped sp", {12'h0, sp}, 14'h1);
        for (int i = 0; i < 5; i++) begin
            exec(24'h400000);
            check("R13 wrapped return", pc, exp_ret[i]);
        end
        check("R13 final sp", {12'h0, sp}, 14'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hold();
        t_sequential();
        t_flags();
        t_dp();
        t_rqm();
        t_serial();
        t_abs();
        t_reset();
        t_call_ret();
        t_unlisted();
        t_wrap();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule